// File: doc/BRIEF.md
# Glitch-free three-source clock switcher

This block chooses the system clock from three free-running sources: a primary clock, a slow secondary oscillator clock and an internal oscillator clock. A two-bit select field is written from the control domain. A flag that says whether the secondary oscillator is enabled decides whether a request for the secondary source is allowed. When the selection changes, the block first shuts off the old source and then turns on the new one. Each step goes through a synchronizer in the domain of the clock it controls. The output is therefore held low between the two sources and never shows a shortened pulse.

Three status flags report which source is driving the output once a handoff has settled. The primary flag also waits for the primary start-up timer to expire. The internal flag also waits for the internal block to report stable, and it stays clear while the internal output comes from the low-power RC. If the select field changes while a handoff is in progress, the block keeps the new value and carries it out once the current handoff has finished.

Top module: `clksw_top`

## Requirements
- R1: While reset is high and after it is released, the readback of the select field is 00 and all status flags are clear during reset. Once the block settles after reset, the output follows the primary clock.
- R2: Select encoding: 00 picks the primary clock, 01 picks the secondary clock, and 10 or 11 pick the internal clock. After a handoff settles, the output follows the chosen source.
- R3: A write of 01 while the secondary enable input is low is dropped. The readback and the driving source stay as they were.
- R4: On a switch, the output low interval between the last pulse of the old source and the first pulse of the new source lasts at least two and a half periods of the new source.
- R5: No high or low phase of the output is shorter than the shortest half period of the sources, and at no time are two source gates open together.
- R6: At most one status flag is set at any time, and all flags are clear while a handoff is in progress.
- R7: The primary flag is set only while the primary clock is driving and the primary-ready input is high. It rises within a few cycles after ready rises.
- R8: The internal flag is set only while the internal clock is driving, the stable input is high and the low-power RC indication is low.
- R9: The secondary flag is set once the secondary clock is driving the output.
- R10: A select write made during a handoff is retained. The output ends on the most recently accepted selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the select field |
| sel_in | input | 2 | New select value |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| pri_clk | input | 1 | Primary clock source |
| sec_clk | input | 1 | Secondary (slow) clock source |
| int_clk | input | 1 | Internal oscillator clock source |
| pri_ready | input | 1 | Primary start-up timer expired |
| int_stable | input | 1 | Internal oscillator block stable |
| int_lp_rc | input | 1 | Internal output currently from low-power RC |
| clk_out | output | 1 | Switched system clock |
| sel_cur | output | 2 | Readback of accepted select field |
| stat_pri | output | 1 | Primary source is driving |
| stat_int | output | 1 | Internal block is driving and stable |
| stat_sec | output | 1 | Secondary source is driving |

## Verification
The bench uses the default SYNC_STAGES of 2. With that depth the old gate closes after two falling edges, and the new gate opens after three falling edges of its own clock. The two-and-a-half-period lower bound on the low gap is therefore an exact limit that can be measured, not a loose one. The three source clocks have half periods of 7, 11 and 45 ns and run against an 8 ns control clock. The lengths of these clocks are unrelated, so handoffs start at many different phase offsets. The slowest source also makes mid-handoff rewrites of the select field easy to hit.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DROP  = 2'd1,
        ST_RAISE = 2'd2
    } hand_e;

    typedef struct packed {
        logic on_pri;
        logic on_int;
        logic on_sec;
    } stat_t;

    function automatic src_e sel_to_src(input logic [SEL_W-1:0] sel);
        case (sel)
            2'b00:   return SRC_PRI;
            2'b01:   return SRC_SEC;
            default: return SRC_INT;
        endcase
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], d};
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic rst,
    input  logic req,
    output logic en,
    output logic gclk
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          en_q;

    // Falling-edge chain: the gate closes STAGES edges after req drops,
    // and opens one edge later than that after req rises.
    always_ff @(negedge src_clk) begin
        if (rst) begin
            chain <= '0;
            en_q  <= 1'b0;
        end else begin
            chain <= {chain[LAST-1:0], req};
            en_q  <= chain[LAST] & chain[LAST-1];
        end
    end

    assign en   = en_q;
    assign gclk = src_clk & en_q;
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_in,
    input  logic               sec_osc_en,
    input  logic               pri_ready,
    input  logic               int_stable,
    input  logic               int_lp_rc,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] req,
    output logic [SEL_W-1:0]   sel_cur,
    output stat_t              stat
);
    logic [SEL_W-1:0]   sel_q;
    src_e               cur_q;
    src_e               tgt_q;
    hand_e              state_q;
    logic [NUM_SRC-1:0] req_q;
    stat_t              stat_q;
    logic               accept;
    src_e               want;
    logic               settled;

    assign accept  = sel_wr && !(sel_in == 2'b01 && !sec_osc_en);
    assign want    = sel_to_src(sel_q);
    assign settled = (state_q == ST_IDLE) && (ack == src_onehot(cur_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            cur_q   <= SRC_PRI;
            tgt_q   <= SRC_PRI;
            state_q <= ST_RAISE;
            req_q   <= src_onehot(SRC_PRI);
        end else begin
            if (accept) begin
                sel_q <= sel_in;
            end
            case (state_q)
                ST_IDLE: begin
                    if (want != cur_q) begin
                        tgt_q   <= want;
                        req_q   <= '0;
                        state_q <= ST_DROP;
                    end
                end
                ST_DROP: begin
                    if (ack == '0) begin
                        cur_q   <= tgt_q;
                        req_q   <= src_onehot(tgt_q);
                        state_q <= ST_RAISE;
                    end
                end
                ST_RAISE: begin
                    if (ack == src_onehot(cur_q)) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    req_q   <= '0;
                    state_q <= ST_DROP;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.on_pri <= settled && (cur_q == SRC_PRI) && pri_ready;
            stat_q.on_int <= settled && (cur_q == SRC_INT) && int_stable && !int_lp_rc;
            stat_q.on_sec <= settled && (cur_q == SRC_SEC);
        end
    end

    assign req     = req_q;
    assign sel_cur = sel_q;
    assign stat    = stat_q;
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             sec_osc_en,
    input  logic             pri_clk,
    input  logic             sec_clk,
    input  logic             int_clk,
    input  logic             pri_ready,
    input  logic             int_stable,
    input  logic             int_lp_rc,
    output logic             clk_out,
    output logic [SEL_W-1:0] sel_cur,
    output logic             stat_pri,
    output logic             stat_int,
    output logic             stat_sec
);
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] gate_en;
    logic [NUM_SRC-1:0] gclk;
    logic [NUM_SRC-1:0] ack;
    stat_t              stat;

    assign src_clk[SRC_PRI] = pri_clk;
    assign src_clk[SRC_SEC] = sec_clk;
    assign src_clk[SRC_INT] = int_clk;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            clksw_gate #(.STAGES(SYNC_STAGES)) u_gate (
                .src_clk (src_clk[g]),
                .rst     (rst),
                .req     (req[g]),
                .en      (gate_en[g]),
                .gclk    (gclk[g])
            );
            clksw_sync #(.STAGES(SYNC_STAGES)) u_ack (
                .clk (clk),
                .rst (rst),
                .d   (gate_en[g]),
                .q   (ack[g])
            );
        end
    endgenerate

    clksw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sel_wr     (sel_wr),
        .sel_in     (sel_in),
        .sec_osc_en (sec_osc_en),
        .pri_ready  (pri_ready),
        .int_stable (int_stable),
        .int_lp_rc  (int_lp_rc),
        .ack        (ack),
        .req        (req),
        .sel_cur    (sel_cur),
        .stat       (stat)
    );

    assign clk_out  = |gclk;
    assign stat_pri = stat.on_pri;
    assign stat_int = stat.on_int;
    assign stat_sec = stat.on_sec;
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk
    import clksw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sel_wr,
    input logic [SEL_W-1:0]   sel_in,
    input logic               sec_osc_en,
    input logic               pri_ready,
    input logic               int_stable,
    input logic               int_lp_rc,
    input logic [SEL_W-1:0]   sel_cur,
    input logic               stat_pri,
    input logic               stat_int,
    input logic               stat_sec,
    input logic [NUM_SRC-1:0] gate_en
);
    AST_RESET_SEL: assert property (@(posedge clk) $past(rst) |-> sel_cur == 2'b00); // R1

    AST_SEC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && sel_in == 2'b01 && !sec_osc_en) |=> $stable(sel_cur)); // R3

    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_en)); // R5

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stat_pri, stat_int, stat_sec})); // R6

    AST_PRI_READY: assert property (@(posedge clk) disable iff (rst)
        stat_pri |-> $past(pri_ready)); // R7

    AST_INT_STABLE: assert property (@(posedge clk) disable iff (rst)
        stat_int |-> $past(int_stable && !int_lp_rc)); // R8
endmodule

bind clksw_top clksw_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_wr     (sel_wr),
    .sel_in     (sel_in),
    .sec_osc_en (sec_osc_en),
    .pri_ready  (pri_ready),
    .int_stable (int_stable),
    .int_lp_rc  (int_lp_rc),
    .sel_cur    (sel_cur),
    .stat_pri   (stat_pri),
    .stat_int   (stat_int),
    .stat_sec   (stat_sec),
    .gate_en    (gate_en)
);

// File: tb/sim_clksw_top.sv
module sim_clksw_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_in = 2'b00;
    logic       sec_osc_en = 1'b0;
    logic       pri_clk = 1'b0;
    logic       sec_clk = 1'b0;
    logic       int_clk = 1'b0;
    logic       pri_ready = 1'b1;
    logic       int_stable = 1'b1;
    logic       int_lp_rc = 1'b0;
    logic       clk_out;
    logic [1:0] sel_cur;
    logic       stat_pri, stat_int, stat_sec;

    int  n_chk = 0;
    int  n_fail = 0;
    real last_edge = 0.0;
    real last_fall = 0.0;
    real min_phase = 1.0e9;
    real max_low = 0.0;
    bit  seen_edge = 1'b0;

    always #4  clk     = ~clk;
    always #7  pri_clk = ~pri_clk;
    always #11 int_clk = ~int_clk;
    always #45 sec_clk = ~sec_clk;

    clksw_top u0 (
        .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_in(sel_in),
        .sec_osc_en(sec_osc_en), .pri_clk(pri_clk), .sec_clk(sec_clk),
        .int_clk(int_clk), .pri_ready(pri_ready), .int_stable(int_stable),
        .int_lp_rc(int_lp_rc), .clk_out(clk_out), .sel_cur(sel_cur),
        .stat_pri(stat_pri), .stat_int(stat_int), .stat_sec(stat_sec)
    );

    always @(clk_out) begin
        if (seen_edge && ($realtime - last_edge) < min_phase)
            min_phase = $realtime - last_edge;
        seen_edge = 1'b1;
        last_edge = $realtime;
        if (clk_out === 1'b0)
            last_fall = $realtime;
        else if (($realtime - last_fall) > max_low)
            max_low = $realtime - last_fall;
    end

    task automatic chk_val(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    task automatic wr(input logic [1:0] v);
        @(posedge clk); #0.5;
        sel_wr = 1'b1; sel_in = v;
        @(posedge clk); #0.5;
        sel_wr = 1'b0;
    endtask

    task automatic chk_follow(input string rq, input int which);
        int bad = 0;
        logic exp_v;
        for (int i = 0; i < 24; i++) begin
            #3;
            case (which)
                0:       exp_v = pri_clk;
                1:       exp_v = sec_clk;
                default: exp_v = int_clk;
            endcase
            if (clk_out !== exp_v) bad++;
        end
        chk_val(rq, "output follow mismatches", bad, 0);
    endtask

    task automatic chk_stat(input string rq, input int p, input int i, input int s);
        chk_val(rq, "status {pri,int,sec}", {stat_pri, stat_int, stat_sec}, (p << 2) | (i << 1) | s);
    endtask

    task automatic switch_to(input string rq, input logic [1:0] v, input int which, input real per);
        max_low = 0.0;
        wr(v);
        tick(300);
        chk_val(rq, "sel_cur", sel_cur, v);
        chk_follow(rq, which);
        n_chk++;
        if (max_low < 2.5 * per - 0.1) begin
            n_fail++;
            $display("FAIL R4 low gap: actual %0.1f expected >= %0.1f", max_low, 2.5 * per);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(20);
        chk_stat("R1", 0, 0, 0);
        chk_val("R1", "sel_cur in reset", sel_cur, 0);
        tick(20);
        rst = 1'b0;
        tick(1);
        chk_val("R1", "sel_cur after reset", sel_cur, 0);
        tick(300);
        chk_follow("R1", 0);
        chk_stat("R7", 1, 0, 0);
    endtask

    task automatic t_ignore_sec;
        sec_osc_en = 1'b0;
        wr(2'b01);
        tick(300);
        chk_val("R3", "sel_cur", sel_cur, 0);
        chk_follow("R3", 0);
        chk_stat("R3", 1, 0, 0);
    endtask

    task automatic t_sources;
        sec_osc_en = 1'b1;
        switch_to("R2", 2'b01, 1, 90.0);
        chk_stat("R9", 0, 0, 1);
        switch_to("R2", 2'b10, 2, 22.0);
        chk_stat("R8", 0, 1, 0);
        int_lp_rc = 1'b1;
        tick(4);
        chk_stat("R8", 0, 0, 0);
        int_lp_rc = 1'b0;
        int_stable = 1'b0;
        tick(4);
        chk_stat("R8", 0, 0, 0);
        int_stable = 1'b1;
        tick(4);
        chk_stat("R8", 0, 1, 0);
    endtask

    task automatic t_pri_ready;
        pri_ready = 1'b0;
        switch_to("R2", 2'b00, 0, 14.0);
        chk_stat("R7", 0, 0, 0);
        pri_ready = 1'b1;
        tick(4);
        chk_stat("R7", 1, 0, 0);
        switch_to("R2", 2'b11, 2, 22.0);
        chk_stat("R6", 0, 1, 0);
    endtask

    task automatic t_pending;
        wr(2'b01);
        tick(3);
        chk_stat("R6", 0, 0, 0);
        wr(2'b00);
        tick(700);
        chk_val("R10", "sel_cur", sel_cur, 0);
        chk_follow("R10", 0);
        chk_stat("R10", 1, 0, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ignore_sec();
        t_sources();
        t_pri_ready();
        t_pending();
        n_chk++;
        if (min_phase < 7.0 - 0.1) begin
            n_fail++;
            $display("FAIL R5 shortest phase: actual %0.1f expected >= 7.0", min_phase);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule